// File: doc/BRIEF.md
# Mode-Dependent Port Function Control Register

This block is a one-byte control register that decides, pin by pin, whether each line of an 8-bit port carries a bus-control function, a calibration output, a clock-test output, instruction-pipe status or plain general-purpose I/O. The chip operating mode is sampled while reset is asserted and held from then on. That mode picks the reset contents of the register, which bits may be written and when, and whether the register can be reached at all.

Software reads and writes the register through a select, a write strobe and a data byte. The block turns the stored bits into a 3-bit function code for each pin. The pad multiplexers consume these codes directly. Where two functions compete for one pin, a fixed priority decides the winner.

Top module: `portfn_ctrl`

## Requirements
- R1: Mode encoding is 0 single-chip, 1 normal expanded, 2 special expanded, 3 peripheral. After reset the readable value is 8'h80 in single-chip, 8'h10 in normal expanded, 8'h3C in special expanded. Modes 2 and 3 are the special modes.
- R2: In peripheral mode, rdata is always 0 and writes change nothing. The clock-test bit (bit 6) resets to 1 there, so pin 6 reports the clock-test code.
- R3: In modes 0 and 1, the data-enable-off bit (bit 7) takes the value of the first accepted write and ignores every later write.
- R4: In mode 2, the first accepted write leaves bit 7 unchanged, and every later write loads it.
- R5: The clock-test bit (bit 6) never changes in modes 0 and 1. In mode 2, it ignores the first accepted write and loads on every later one.
- R6: Bits 5..1 load on every accepted write in modes 0 to 2, and bit 0 always reads 0. Every accepted write counts as "first" for the rules of bits 7 and 6, whatever its data.
- R7: Pin function codes are 0 GPIO, 1 bus, 2 calibration, 3 clock test, 4 pipe status. Pin i occupies pin_fn[3i+2:3i]. In modes 1 and 2, pin 7 is bus when bit 7 is 0. Otherwise, and always in modes 0 and 3, pin 7 is calibration when bit 1 is set and GPIO when it is clear.
- R8: Pin 6 is pipe when bit 5 is set. Otherwise it is clock test when bit 6 is set in mode 2 or 3. Otherwise it is GPIO.
- R9: Pin 5 is pipe when bit 5 is set. Pins 4, 3 and 2 are bus when bits 4, 3 and 2 respectively are set. Each of these pins is GPIO otherwise, and pins 1 and 0 are always GPIO.
- R10: A change on the mode input after reset has no effect on access, write rules or pin codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is sampled while low |
| mode | input | 2 | Operating mode |
| sel | input | 1 | Register select |
| wr | input | 1 | Write strobe, valid with sel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when not selected |
| pin_fn | output | 24 | Per-pin function codes, 3 bits per pin |

## Verification
Two things can land in the same cycle: the write that is the first one seen, and a pin code driven by the bit that write targets. Both ignore-first rules and the write-once rule therefore resolve on that single edge. The bench issues writes of all-ones and all-zeros directly after reset in every mode, and then random bytes. After each write it compares the read-back value and all eight pin codes against a rule model. The model is kept in the bench and written from the requirements. A mode flip after reset shows whether those outcomes still follow the mode latched at reset.

// File: rtl/portfn_pkg.sv
// Package: shared encodings, bit positions and reset defaults for the
// port function control register. Assumes an 8-bit port.
package portfn_pkg;

    localparam int PORT_W = 8;
    localparam int FN_W   = 3;

    typedef enum logic [1:0] {
        MD_SINGLE = 2'd0,
        MD_NEXP   = 2'd1,
        MD_SEXP   = 2'd2,
        MD_PERIPH = 2'd3
    } opmode_e;

    typedef enum logic [FN_W-1:0] {
        FN_GPIO = 3'd0,
        FN_BUS  = 3'd1,
        FN_CAL  = 3'd2,
        FN_TEST = 3'd3,
        FN_PIPE = 3'd4
    } pin_fn_e;

    typedef enum logic [1:0] {
        WR_FREE,       // loads on every accepted write
        WR_ONCE_SKIP,  // once in normal modes, all but first in special
        WR_NEVER_SKIP  // never in normal modes, all but first in special
    } wrule_e;

    localparam int B_NDE   = 7;
    localparam int B_CTST  = 6;
    localparam int B_PIPE  = 5;
    localparam int B_ECLK  = 4;
    localparam int B_LSTRB = 3;
    localparam int B_RW    = 2;
    localparam int B_CAL   = 1;

    // Bit 0 is not implemented
    localparam logic [PORT_W-1:0] IMPL_MASK = 8'hFE;

    // Reset contents per operating mode
    function automatic logic [PORT_W-1:0] reset_value(input opmode_e m);
        logic [PORT_W-1:0] v;
        v = '0;
        unique case (m)
            MD_SINGLE: v[B_NDE] = 1'b1;
            MD_NEXP:   v[B_ECLK] = 1'b1;
            MD_SEXP: begin
                v[B_PIPE]  = 1'b1;
                v[B_ECLK]  = 1'b1;
                v[B_LSTRB] = 1'b1;
                v[B_RW]    = 1'b1;
            end
            MD_PERIPH: begin
                v[B_NDE]  = 1'b1;
                v[B_CTST] = 1'b1;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    // Returns the write rule that governs a register bit
    function automatic wrule_e rule_of(input int b);
        if (b == B_NDE)  return WR_ONCE_SKIP;
        if (b == B_CTST) return WR_NEVER_SKIP;
        return WR_FREE;
    endfunction

endpackage

// File: rtl/portfn_wgate.sv
// Write gate for one register bit. It keeps its own "first write seen"
// flag and applies the write rule chosen by RULE. Assumes wr_acc is
// already qualified by select, strobe and accessibility.
module portfn_wgate
    import portfn_pkg::*;
#(
    parameter wrule_e RULE = WR_FREE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_special,
    input  logic wr_acc,
    output logic wen
);

    logic seen_q;

    // Records that an accepted write has occurred since reset
    always_ff @(posedge clk) begin
        if (!rst_n)      seen_q <= 1'b0;
        else if (wr_acc) seen_q <= 1'b1;
    end

    generate
        if (RULE == WR_ONCE_SKIP) begin : g_once
            // Normal: only the first write lands; special: all but the first
            assign wen = wr_acc & (is_special ? seen_q : ~seen_q);
        end else if (RULE == WR_NEVER_SKIP) begin : g_never
            // Normal: never; special: all but the first
            assign wen = wr_acc & is_special & seen_q;
        end else begin : g_free
            assign wen = wr_acc;
        end
    endgenerate

endmodule

// File: rtl/portfn_regs.sv
// Register storage. It latches the operating mode during reset, loads the
// per-mode defaults and applies per-bit write gates. Assumes a
// synchronous active-low reset that is held for at least one edge.
module portfn_regs
    import portfn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              sel,
    input  logic              wr,
    input  logic [PORT_W-1:0] wdata,
    output opmode_e           mode_q,
    output logic [PORT_W-1:0] cfg_q,
    output logic              access_ok
);

    logic              wr_acc;
    logic              is_special;
    logic [PORT_W-1:0] wen;

    assign access_ok  = (mode_q != MD_PERIPH);
    assign is_special = mode_q[1];
    assign wr_acc     = sel & wr & access_ok;

    // Samples the mode while reset is held and freezes it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= opmode_e'(mode);
    end

    generate
        for (genvar b = 0; b < PORT_W; b++) begin : g_bit
            if (IMPL_MASK[b]) begin : g_impl
                portfn_wgate #(.RULE(rule_of(b))) u_gate (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .is_special (is_special),
                    .wr_acc     (wr_acc),
                    .wen        (wen[b])
                );
                // Loads the default at reset, and write data when the gate opens
                always_ff @(posedge clk) begin
                    if (!rst_n)      cfg_q[b] <= reset_value(opmode_e'(mode))[b];
                    else if (wen[b]) cfg_q[b] <= wdata[b];
                end
            end else begin : g_none
                assign wen[b]   = 1'b0;
                assign cfg_q[b] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/portfn_pinmux.sv
// Turns the stored configuration and the latched mode into one function
// code per pin, applying the override priorities. Purely combinational.
module portfn_pinmux
    import portfn_pkg::*;
(
    input  opmode_e                  mode_q,
    input  logic [PORT_W-1:0]        cfg_q,
    output logic [PORT_W*FN_W-1:0]   pin_fn
);

    logic expanded;
    logic special;

    assign expanded = (mode_q == MD_NEXP) || (mode_q == MD_SEXP);
    assign special  = mode_q[1];

    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_pin
            pin_fn_e f;
            if (i == B_NDE) begin : g_p7
                // Data enable in expanded modes, else calibration or GPIO
                always_comb begin
                    if (expanded && !cfg_q[B_NDE]) f = FN_BUS;
                    else if (cfg_q[B_CAL])         f = FN_CAL;
                    else                           f = FN_GPIO;
                end
            end else if (i == B_CTST) begin : g_p6
                // Pipe status beats clock test, which needs a special mode
                always_comb begin
                    if (cfg_q[B_PIPE])                f = FN_PIPE;
                    else if (special && cfg_q[B_CTST]) f = FN_TEST;
                    else                              f = FN_GPIO;
                end
            end else if (i == B_PIPE) begin : g_p5
                assign f = cfg_q[B_PIPE] ? FN_PIPE : FN_GPIO;
            end else if (i >= B_RW) begin : g_bus
                assign f = cfg_q[i] ? FN_BUS : FN_GPIO;
            end else begin : g_io
                assign f = FN_GPIO;
            end
            assign pin_fn[i*FN_W +: FN_W] = f;
        end
    endgenerate

endmodule

// File: rtl/portfn_ctrl.sv
// Top: mode-dependent port function control register. It combines the
// storage and write rules with the pin multiplexer selects. Read data is
// combinational and zero unless selected and accessible.
module portfn_ctrl
    import portfn_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode,
    input  logic                   sel,
    input  logic                   wr,
    input  logic [PORT_W-1:0]      wdata,
    output logic [PORT_W-1:0]      rdata,
    output logic [PORT_W*FN_W-1:0] pin_fn
);

    opmode_e           mode_q;
    logic [PORT_W-1:0] cfg_q;
    logic              access_ok;

    portfn_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .sel       (sel),
        .wr        (wr),
        .wdata     (wdata),
        .mode_q    (mode_q),
        .cfg_q     (cfg_q),
        .access_ok (access_ok)
    );

    portfn_pinmux u_mux (
        .mode_q (mode_q),
        .cfg_q  (cfg_q),
        .pin_fn (pin_fn)
    );

    // Read path: masked register value when reachable
    assign rdata = (sel && access_ok) ? (cfg_q & IMPL_MASK) : '0;

endmodule

// File: rtl/portfn_ctrl_chk.sv
// Checker for portfn_ctrl, bound into every instance. It tracks its own
// "first write seen" flag, independent of the design's gates.
module portfn_ctrl_chk
    import portfn_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sel,
    input logic                   wr,
    input logic [PORT_W-1:0]      rdata,
    input logic [PORT_W*FN_W-1:0] pin_fn,
    input opmode_e                mode_q,
    input logic [PORT_W-1:0]      cfg_q
);

    logic chk_seen;
    logic acc;

    assign acc = sel & wr & (mode_q != MD_PERIPH);

    // Independent record of the first accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)   chk_seen <= 1'b0;
        else if (acc) chk_seen <= 1'b1;
    end

    // R2
    periph_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_PERIPH) |-> (rdata == '0));

    // R3
    nde_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[1] && chk_seen && acc) |=> $stable(cfg_q[B_NDE]));

    // R4
    nde_skip_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && !chk_seen && acc) |=> $stable(cfg_q[B_NDE]));

    // R5
    ctst_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[1] |=> $stable(cfg_q[B_CTST]));

    // R7
    pin7_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MD_NEXP || mode_q == MD_SEXP) && !cfg_q[B_NDE])
        |-> (pin_fn[B_NDE*FN_W +: FN_W] == FN_BUS));

    // R8
    pipe_over_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[B_PIPE] |-> (pin_fn[B_CTST*FN_W +: FN_W] == FN_PIPE));

    // R10
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

endmodule

bind portfn_ctrl portfn_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .wr     (wr),
    .rdata  (rdata),
    .pin_fn (pin_fn),
    .mode_q (mode_q),
    .cfg_q  (cfg_q)
);

// File: tb/portfn_ctrl_tb_top.sv
// Bench for portfn_ctrl: directed corner writes plus seeded random bytes
// in every mode, compared with a rule model built from the requirements.
module portfn_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        sel, wr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic [23:0] pin_fn;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Model state
    logic [1:0] m_mode;
    logic [7:0] m_reg;
    bit         m_seen;

    always #4 clk = ~clk; // 125 MHz

    portfn_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .wr(wr),
        .wdata(wdata), .rdata(rdata), .pin_fn(pin_fn)
    );

    // Expected reset contents (R1, R2)
    function automatic logic [7:0] exp_reset(input logic [1:0] m);
        case (m)
            2'd0: return 8'h80;
            2'd1: return 8'h10;
            2'd2: return 8'h3C;
            default: return 8'hC0;
        endcase
    endfunction

    // Expected pin codes (R7, R8, R9)
    function automatic logic [23:0] exp_pins(input logic [1:0] m, input logic [7:0] r);
        logic [23:0] p;
        p = '0;
        if ((m == 2'd1 || m == 2'd2) && !r[7]) p[23:21] = 3'd1;
        else if (r[1])                          p[23:21] = 3'd2;
        if (r[5])              p[20:18] = 3'd4;
        else if (m[1] && r[6]) p[20:18] = 3'd3;
        if (r[5]) p[17:15] = 3'd4;
        for (int i = 2; i <= 4; i++) if (r[i]) p[i*3 +: 3] = 3'd1;
        return p;
    endfunction

    // Applies one accepted write to the model (R3 to R6)
    function automatic void model_write(input logic [7:0] d);
        if (m_mode == 2'd3) return;
        m_reg[5:1] = d[5:1];
        if (!m_mode[1]) begin
            if (!m_seen) m_reg[7] = d[7];
        end else begin
            if (m_seen) begin
                m_reg[7] = d[7];
                m_reg[6] = d[6];
            end
        end
        m_seen = 1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reads the register and checks both the read data and the pin codes
    task automatic check_all(input string tag);
        @(negedge clk);
        sel = 1; wr = 0;
        #1;
        check({tag, " rdata"}, {24'd0, rdata}, {24'd0, (m_mode == 2'd3) ? 8'h00 : (m_reg & 8'hFE)});
        check({tag, " pins"},  {8'd0, pin_fn}, {8'd0, exp_pins(m_mode, m_reg)});
        sel = 0;
    endtask

    task automatic do_write(input logic [7:0] d, input string tag);
        @(negedge clk);
        sel = 1; wr = 1; wdata = d;
        @(posedge clk);
        model_write(d);
        @(negedge clk);
        sel = 0; wr = 0;
        check_all(tag);
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n = 0; mode = m; sel = 0; wr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_mode = m; m_reg = exp_reset(m); m_seen = 0;
    endtask

    initial begin
        int r;
        r = $urandom(32'd2718);
        rst_n = 0; mode = 0; sel = 0; wr = 0; wdata = 0;
        for (int m = 0; m < 4; m++) begin
            do_reset(2'(m));
            check_all("R1 reset defaults");
            // Directed: all-ones first hits the first-write rules (R3 R4 R5 R6)
            do_write(8'hFF, "R3 R4 R5 first write");
            do_write(8'h00, "R3 R4 R5 second write");
            do_write(8'hC2, "R7 R8 pin6 pin7");
            do_write(8'h22, "R8 pipe priority");
            do_write(8'h1C, "R9 bus pins");
            for (int k = 0; k < 30; k++)
                do_write(8'($urandom), (m == 3) ? "R2 periph random" : "R6 random write");
        end
        // R2: peripheral pin 6 carries clock test after reset
        do_reset(2'd3);
        @(negedge clk); #1;
        check("R2 pin6 test", {29'd0, pin_fn[20:18]}, 32'd3);
        // R10: mode input flips after reset in normal expanded
        do_reset(2'd1);
        @(negedge clk);
        mode = 2'd3;
        do_write(8'h40, "R10 mode flip write");
        mode = 2'd2;
        do_write(8'h82, "R10 mode flip second");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule